// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations in a small, fully associative array. Each entry is tagged with a process identifier as well as a virtual page number, so translations that belong to different processes can sit side by side. A lookup carries a process id, a virtual address and a read/write flag. One cycle after it is accepted, the block answers with one of three results: a hit with the physical address, a protection fault, or a miss. The physical address is the cached frame number joined to the unchanged page offset.

On a miss the block raises a miss request that carries the missing tag, and it stops accepting lookups. It waits until an external page-table walker writes a refill or a flush cancels the wait. A refill is placed in one of three slots, in this order: the slot that already holds the same tag, the lowest free slot, or a slot picked by a free-running LFSR. Each entry keeps a dirty bit and a referenced bit. Hits update both bits, and every response reports them so that software can build an approximate-LRU policy. A flush for context switches invalidates every entry in a single cycle.

Lookups use a valid/ready handshake. `req_ready` is low while a miss is pending and during a flush cycle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the request fields must stay stable while `req_valid` waits. The response is a one-cycle `rsp_valid` pulse with no back-pressure, so the requester must take it when it appears. Refill and flush are plain inputs that are sampled on every edge.

Top module: `ptag_tlb`

## Requirements
- R1: After reset, every entry is invalid, `rsp_valid` and `miss_valid` are low, `req_ready` is high, and the first lookup misses.
- R2: An accepted lookup gives a `rsp_valid` pulse exactly one cycle later. On a hit, `rsp_paddr` is the entry's frame number with the request's low OFF_W address bits appended unchanged.
- R3: An entry hits only when both the process id and the virtual page number match. The same page number under two process ids can hold two different frames at once.
- R4: A miss returns `rsp_hit`=0 and `rsp_fault`=0. In the same cycle `miss_valid` rises, `miss_pid`/`miss_vpn` hold the missing tag, and `req_ready` stays low until a refill or a flush.
- R5: A refill that is accepted (`refill_valid` high, `flush` low) installs its entry with dirty=0 and referenced=0, and it clears a pending miss. A refill whose tag is already cached overwrites that entry in place.
- R6: A write that matches an entry whose writable flag is 0 returns `rsp_fault`=1 and `rsp_hit`=0, and it leaves the dirty bit unchanged. A write that matches a writable entry hits and sets the dirty bit.
- R7: On a matching access, `rsp_dirty` is the entry's dirty bit after this access and `rsp_referenced` is the entry's referenced bit before it. Every matching access, faulting or not, sets the referenced bit. On a miss, both outputs are 0.
- R8: While `flush` is high, `req_ready` is low. On the next cycle every entry is invalid and `miss_valid` is low, and a refill presented in the flush cycle is dropped.
- R9: Refills go to the lowest free slot. When all ENTRIES slots are valid, a refill of a new tag replaces exactly one slot chosen by the LFSR; the new tag then hits and at least one older tag misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted |
| req_pid | input | PID_W | Process id of the lookup |
| req_vaddr | input | VPN_W+OFF_W | Virtual address |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_fault | output | 1 | Write to a read-only entry |
| rsp_paddr | output | PFN_W+OFF_W | Physical address on a hit, else 0 |
| rsp_dirty | output | 1 | Entry dirty bit after this access |
| rsp_referenced | output | 1 | Entry referenced bit before this access |
| miss_valid | output | 1 | Miss pending, waiting for refill |
| miss_pid | output | PID_W | Process id of the pending miss |
| miss_vpn | output | VPN_W | Page number of the pending miss |
| refill_valid | input | 1 | Refill write strobe |
| refill_pid | input | PID_W | Refill process id |
| refill_vpn | input | VPN_W | Refill page number |
| refill_pfn | input | PFN_W | Refill frame number |
| refill_writable | input | 1 | Refill write permission |
| flush | input | 1 | Invalidate all entries |

## Verification
Lookups are run as reads and writes against entries that are writable and read-only, with a different page offset each time. This checks that the offset is carried through and that a fault is kept apart from a hit. The same page is requested under two process ids, which shows that a match needs the pid as well as the page number. Repeated accesses to one entry show that the referenced and dirty bits report the entry's history, and a re-refill of a cached tag shows that it overwrites in place and clears that history. Flushes are issued alone, with a miss pending, and in the same cycle as a refill. A final pass fills every slot and adds one more tag, which shows that exactly one old translation is lost.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    RK_MISS  = 2'd0,
    RK_HIT   = 2'd1,
    RK_FAULT = 2'd2
  } rsp_kind_e;

  // maximal-length feedback mask for an 8-bit shift register
  localparam int unsigned LFSR_TAPS_DEFAULT = 32'h0000_00B8;

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int          W     = 8,
  parameter int          IDX_W = 4,
  parameter int unsigned TAPS  = tlb_pkg::LFSR_TAPS_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] rnd_idx
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb      = ^(state_q & W'(TAPS));
  assign rnd_idx = state_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= W'(1);
    else        state_q <= {state_q[W-2:0], fb};
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 16,
  parameter int TAG_W = 28,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [N-1:0]            valid,
  input  logic [TAG_W-1:0]        key,
  output logic                    any,
  output logic [IDX_W-1:0]        idx
);
  logic [N-1:0] hits;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     valid,
  input  logic             same_any,
  input  logic [IDX_W-1:0] same_idx,
  input  logic [IDX_W-1:0] rnd_idx,
  output logic [IDX_W-1:0] idx
);
  logic             free_any;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    if (same_any)      idx = same_idx;
    else if (free_any) idx = free_idx;
    else               idx = rnd_idx;
  end
endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb #(
  parameter int ENTRIES = 16,
  parameter int PID_W   = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int LFSR_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [PID_W-1:0]       req_pid,
  input  logic [VPN_W+OFF_W-1:0] req_vaddr,
  input  logic                   req_write,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_fault,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic                   rsp_dirty,
  output logic                   rsp_referenced,
  output logic                   miss_valid,
  output logic [PID_W-1:0]       miss_pid,
  output logic [VPN_W-1:0]       miss_vpn,
  input  logic                   refill_valid,
  input  logic [PID_W-1:0]       refill_pid,
  input  logic [VPN_W-1:0]       refill_vpn,
  input  logic [PFN_W-1:0]       refill_pfn,
  input  logic                   refill_writable,
  input  logic                   flush
);
  import tlb_pkg::*;

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PID_W + VPN_W;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;

  // entry state
  logic [ENTRIES-1:0]            vld_q, wr_q, dirty_q, ref_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;

  logic             lk_any, rf_any;
  logic [IDX_W-1:0] lk_idx, rf_idx, rnd_idx, vic_idx;
  logic [TAG_W-1:0] lk_key, rf_key;
  logic [OFF_W-1:0] lk_off;
  logic             accept, refill_go, miss_q;
  rsp_kind_e        kind;

  assign lk_key    = {req_pid, req_vaddr[VA_W-1:OFF_W]};
  assign lk_off    = req_vaddr[OFF_W-1:0];
  assign rf_key    = {refill_pid, refill_vpn};
  assign req_ready = !miss_q && !flush;
  assign accept    = req_valid && req_ready;
  assign refill_go = refill_valid && !flush;

  tlb_cam #(.N(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lookup_cam (
    .tags(tag_q), .valid(vld_q), .key(lk_key), .any(lk_any), .idx(lk_idx)
  );

  tlb_cam #(.N(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_refill_cam (
    .tags(tag_q), .valid(vld_q), .key(rf_key), .any(rf_any), .idx(rf_idx)
  );

  tlb_lfsr #(.W(LFSR_W), .IDX_W(IDX_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd_idx(rnd_idx)
  );

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid(vld_q), .same_any(rf_any), .same_idx(rf_idx),
    .rnd_idx(rnd_idx), .idx(vic_idx)
  );

  always_comb begin
    if (!lk_any)                          kind = RK_MISS;
    else if (req_write && !wr_q[lk_idx])  kind = RK_FAULT;
    else                                  kind = RK_HIT;
  end

  // valid / permission / history bits; a refill overrides a same-slot hit update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      wr_q    <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
    end else if (flush) begin
      vld_q   <= '0;
    end else begin
      if (accept && lk_any) begin
        ref_q[lk_idx] <= 1'b1;
        if (kind == RK_HIT && req_write) dirty_q[lk_idx] <= 1'b1;
      end
      if (refill_go) begin
        vld_q[vic_idx]   <= 1'b1;
        wr_q[vic_idx]    <= refill_writable;
        dirty_q[vic_idx] <= 1'b0;
        ref_q[vic_idx]   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (refill_go) begin
      tag_q[vic_idx] <= rf_key;
      pfn_q[vic_idx] <= refill_pfn;
    end
  end

  // response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_dirty      <= 1'b0;
      rsp_referenced <= 1'b0;
    end else begin
      rsp_valid      <= accept;
      rsp_hit        <= accept && (kind == RK_HIT);
      rsp_fault      <= accept && (kind == RK_FAULT);
      rsp_paddr      <= (accept && kind == RK_HIT) ? PA_W'({pfn_q[lk_idx], lk_off}) : '0;
      rsp_dirty      <= accept && lk_any &&
                        (dirty_q[lk_idx] || (kind == RK_HIT && req_write));
      rsp_referenced <= accept && lk_any && ref_q[lk_idx];
    end
  end

  // miss handshake
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_q   <= 1'b0;
      miss_pid <= '0;
      miss_vpn <= '0;
    end else if (flush) begin
      miss_q   <= 1'b0;
    end else if (accept && kind == RK_MISS) begin
      miss_q   <= 1'b1;
      miss_pid <= req_pid;
      miss_vpn <= req_vaddr[VA_W-1:OFF_W];
    end else if (refill_go) begin
      miss_q   <= 1'b0;
    end
  end

  assign miss_valid = miss_q;
endmodule

// File: rtl/ptag_tlb_chk.sv
module ptag_tlb_chk #(
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OFF_W-1:0] req_off,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_fault,
  input logic [OFF_W-1:0] rsp_off,
  input logic             miss_valid,
  input logic             refill_valid,
  input logic             flush
);
  p_rsp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!rsp_hit || rsp_off == $past(req_off)));

  p_fault_not_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && !rsp_hit));

  p_miss_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> !req_ready);

  p_refill_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && refill_valid) |=> !miss_valid);

  p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !req_ready);

  p_flush_cancels_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!miss_valid && !rsp_valid));
endmodule

bind ptag_tlb ptag_tlb_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_off(req_vaddr[OFF_W-1:0]), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_fault(rsp_fault), .rsp_off(rsp_paddr[OFF_W-1:0]),
  .miss_valid(miss_valid), .refill_valid(refill_valid), .flush(flush)
);

// File: tb/ptag_tlb_test.sv
module ptag_tlb_test;
  localparam int PID_W = 8, VPN_W = 20, PFN_W = 20, OFF_W = 12, N = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [PID_W-1:0] req_pid = '0;
  logic [VPN_W+OFF_W-1:0] req_vaddr = '0;
  logic refill_valid = 0, refill_writable = 0, flush = 0;
  logic [PID_W-1:0] refill_pid = '0;
  logic [VPN_W-1:0] refill_vpn = '0;
  logic [PFN_W-1:0] refill_pfn = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fault, rsp_dirty, rsp_referenced, miss_valid;
  logic [PFN_W+OFF_W-1:0] rsp_paddr;
  logic [PID_W-1:0] miss_pid;
  logic [VPN_W-1:0] miss_vpn;

  ptag_tlb uut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 0, acc_d = 0, m_miss = 0;
  bit [PFN_W-1:0] m_pfn [bit [27:0]];
  bit m_wr [bit [27:0]], m_dirty [bit [27:0]], m_ref [bit [27:0]];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison of handshake outputs against the model
  always @(posedge clk) acc_d <= req_valid && !m_miss && !flush;
  always @(negedge clk) if (mon_on) begin
    chk(req_ready == (!m_miss && !flush), "R4", "req_ready", req_ready, !m_miss && !flush);
    chk(miss_valid == m_miss, "R4", "miss_valid", miss_valid, m_miss);
    chk(rsp_valid == acc_d, "R2", "rsp_valid", rsp_valid, acc_d);
  end

  task automatic refill(bit [7:0] pid, bit [19:0] vpn, bit [19:0] pfn, bit wr, bit model);
    @(posedge clk); #1;
    refill_valid = 1; refill_pid = pid; refill_vpn = vpn; refill_pfn = pfn; refill_writable = wr;
    @(posedge clk); #1;
    refill_valid = 0;
    m_miss = 0;
    if (model) begin
      m_pfn[{pid, vpn}] = pfn; m_wr[{pid, vpn}] = wr;
      m_dirty[{pid, vpn}] = 0; m_ref[{pid, vpn}] = 0;
    end
  endtask

  task automatic do_flush(bit with_refill);
    @(posedge clk); #1;
    flush = 1;
    if (with_refill) begin
      refill_valid = 1; refill_pid = 8'h77; refill_vpn = 20'h00ABC; refill_pfn = 20'h1; refill_writable = 1;
    end
    @(posedge clk); #1;
    flush = 0; refill_valid = 0;
    m_pfn.delete(); m_wr.delete(); m_dirty.delete(); m_ref.delete();
    m_miss = 0;
  endtask

  // raw access; returns observed response just after the edge
  task automatic probe(bit [7:0] pid, bit [19:0] vpn, bit [11:0] off, bit wr, output bit hit);
    @(posedge clk); #1;
    req_valid = 1; req_pid = pid; req_vaddr = {vpn, off}; req_write = wr;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
    hit = rsp_hit;
  endtask

  task automatic lookup(string req, bit [7:0] pid, bit [19:0] vpn, bit [11:0] off, bit wr);
    bit [27:0] k = {pid, vpn};
    bit present = m_pfn.exists(k);
    bit e_fault = present && wr && !m_wr[k];
    bit e_hit = present && !e_fault;
    bit [31:0] e_pa = e_hit ? {m_pfn[k], off} : 32'h0;
    bit e_dirty = present && (m_dirty[k] || (e_hit && wr));
    bit e_ref = present && m_ref[k];
    bit h;
    probe(pid, vpn, off, wr, h);
    if (!present) m_miss = 1;
    else begin
      m_ref[k] = 1;
      if (e_hit && wr) m_dirty[k] = 1;
    end
    @(negedge clk);
    chk(rsp_hit == e_hit, req, "rsp_hit", rsp_hit, e_hit);
    chk(rsp_fault == e_fault, req, "rsp_fault", rsp_fault, e_fault);
    chk(rsp_paddr == e_pa, req, "rsp_paddr", rsp_paddr, e_pa);
    chk(rsp_dirty == e_dirty, req, "rsp_dirty", rsp_dirty, e_dirty);
    chk(rsp_referenced == e_ref, req, "rsp_referenced", rsp_referenced, e_ref);
    if (!present) begin
      chk(miss_pid == pid, req, "miss_pid", miss_pid, pid);
      chk(miss_vpn == vpn, req, "miss_vpn", miss_vpn, vpn);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit h;
    int misses;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
    chk(miss_valid == 0, "R1", "miss_valid", miss_valid, 0);
    chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
    mon_on = 1;
    lookup("R1", 8'h01, 20'h00010, 12'h123, 0);          // first lookup misses (R4 handshake)
    refill(8'h01, 20'h00010, 20'hABCDE, 1, 1);           // R5 releases miss
    lookup("R2", 8'h01, 20'h00010, 12'h456, 0);          // hit, fresh history
    lookup("R7", 8'h01, 20'h00010, 12'hFFF, 0);          // referenced now 1
    // R3: pid tagging
    lookup("R3", 8'h02, 20'h00010, 12'h001, 0);
    refill(8'h02, 20'h00010, 20'h12345, 0, 1);
    lookup("R3", 8'h02, 20'h00010, 12'h002, 0);
    lookup("R3", 8'h01, 20'h00010, 12'h003, 0);
    // R6: write permission
    lookup("R6", 8'h01, 20'h00010, 12'h010, 1);          // writable -> dirty
    lookup("R7", 8'h01, 20'h00010, 12'h011, 0);          // dirty reported on read
    lookup("R6", 8'h02, 20'h00010, 12'h020, 1);          // read-only -> fault
    lookup("R6", 8'h02, 20'h00010, 12'h021, 0);          // dirty still 0
    // R5: refill of a cached tag overwrites in place
    refill(8'h01, 20'h00010, 20'h55555, 0, 1);
    lookup("R5", 8'h01, 20'h00010, 12'h0A0, 0);
    lookup("R5", 8'h02, 20'h00010, 12'h0B0, 0);
    // R8: flush
    do_flush(0);
    lookup("R8", 8'h01, 20'h00010, 12'h0C0, 0);          // miss after flush
    do_flush(0);                                          // cancels pending miss
    do_flush(1);                                          // refill in flush cycle dropped
    lookup("R8", 8'h77, 20'h00ABC, 12'h0D0, 0);
    do_flush(0);
    // R9: fill every slot then overflow
    for (int i = 0; i < N; i++) refill(8'h05, 20'h00100 + 20'(i), 20'h00200 + 20'(i), 1, 1);
    for (int i = 0; i < N; i++) lookup("R9", 8'h05, 20'h00100 + 20'(i), 12'(i * 7), 0);
    refill(8'h05, 20'h001FF, 20'h003FF, 1, 0);
    probe(8'h05, 20'h001FF, 12'h044, 0, h);
    @(negedge clk);
    chk(h == 1, "R9", "new tag hit", h, 1);
    chk(rsp_paddr == 32'h003FF044, "R9", "new tag paddr", rsp_paddr, 32'h003FF044);
    misses = 0;
    for (int i = 0; i < N; i++) begin
      probe(8'h05, 20'h00100 + 20'(i), 12'h0, 0, h);
      if (!h) begin
        misses = 1;
        m_miss = 1;
        @(negedge clk);
        do_flush(0);
        break;
      end
    end
    chk(misses == 1, "R9", "one old tag evicted", misses, 1);
    mon_on = 0;
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule